// File: doc/BRIEF.md
# SD/MMC Command Response Receiver

This block takes in the card's reply on the serial command line after the host has sent a command. Software first arms it and picks two options: short (48-bit) or long (136-bit) reply, and whether CRC7 checking is on. The arming also clears the previous results. Once the command-sent pulse arrives, the block watches the line for a start bit. It then shifts in the reply one bit per serial clock strobe and writes every completed byte into a 17-entry byte store.

When the last bit arrives, the block checks the reply. It checks the framing (transmission bit and end bit) and compares the computed CRC7 against the one received. It then clears its busy bit and raises a sticky end-of-response flag, which can serve directly as an interrupt request. If the line stays high for too many serial clocks, the block ends with a timeout flag instead. Software reads the stored bytes through a byte-wide port whose pointer advances on each read strobe and can be forced back to zero.

Top module: `sdc_resp_rx`

## Requirements
- R1: After reset, `rx_en`, `eor_flag`, `crc_err`, `fmt_err` and `tout_err` are 0. A pulse on `arm_set` while `rx_en` is 0 sets `rx_en` and clears `eor_flag` and all three status bits at the same edge.
- R2: The start-bit search begins only after a `cmd_done` pulse. Before that pulse, line activity leaves the block armed and idle.
- R3: In short mode (`cfg_long`=0), a reply is 48 bits counted from the first 0 seen after `cmd_done`. It fills bytes 0 to 5 of the store, and byte k holds frame bits 8k to 8k+7 in arrival order, with the first-arrived bit as the MSB.
- R4: In long mode (`cfg_long`=1), a reply is 136 bits and fills bytes 0 to 16 with the same byte packing.
- R5: CRC7 uses the polynomial x^7+x^3+1 with a zero start value, fed MSB-first. It covers frame bits 0..39 for a short reply and bits 8..127 for a long reply. The 7 bits just before the end bit hold the received CRC, and a mismatch sets `crc_err` when the reply ends.
- R6: If `cfg_crc_off` was 1 at arming, `crc_err` stays 0 whatever the CRC field holds.
- R7: `fmt_err` is set at the end of a reply if frame bit 1 (the transmission bit) is 1 or the last bit (the end bit) is 0.
- R8: If the line stays high for 64 consecutive strobes after `cmd_done`, the block sets `eor_flag` and `tout_err`, and `crc_err` and `fmt_err` stay 0.
- R9: `eor_flag` rises at the same edge at which `rx_en` falls. It stays set until an `eor_ack` pulse or the next arming.
- R10: `rd_data` shows the byte at the read pointer, and each `rd_en` cycle advances the pointer. The pointer wraps from 16 to 0. While `ptr_rst` is 1, the pointer is held at 0 and `rd_en` has no effect.
- R11: The format and CRC-disable inputs are taken at arming. Changes to them while `rx_en` is 1 have no effect on the reply length or the checks.
- R12: `cmd_in` is sampled only in cycles where `bit_tick` is 1. In other cycles it changes neither the stored bytes nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_set | input | 1 | Pulse that arms reception (sets the busy bit) |
| cfg_long | input | 1 | Reply format: 1 for 136-bit, 0 for 48-bit |
| cfg_crc_off | input | 1 | 1 disables CRC7 checking |
| cmd_done | input | 1 | Pulse at the end of command transmission |
| bit_tick | input | 1 | Serial clock strobe; `cmd_in` is sampled when high |
| cmd_in | input | 1 | Serial command line from the card |
| eor_ack | input | 1 | Pulse clearing the end-of-response flag |
| ptr_rst | input | 1 | Holds the read pointer at zero while high |
| rd_en | input | 1 | Advances the read pointer |
| rd_data | output | 8 | Byte at the read pointer |
| rx_en | output | 1 | Busy / receive-enabled bit |
| eor_flag | output | 1 | Sticky end-of-response flag, usable as interrupt request |
| crc_err | output | 1 | CRC7 mismatch status |
| fmt_err | output | 1 | Framing error status |
| tout_err | output | 1 | No start bit before the timeout |

## Verification
The assertions assume that `arm_set`, `cmd_done` and `eor_ack` are single-cycle pulses. They also assume that `cmd_done` arrives only while the block is armed, and that `eor_ack` and `arm_set` never coincide with the final bit of a reply. The bench drives every control input on the falling clock edge as a one-cycle pulse. It arms only when `rx_en` is low and acknowledges only after `eor_flag` is seen set. Serial bits are given as isolated strobes, sometimes with idle cycles between them in which `cmd_in` carries the opposite value, so the strobe gating is tested without breaking these assumptions.

// File: rtl/sdc_resp_pkg.sv
package sdc_resp_pkg;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_ARMED = 2'd1,
      RX_HUNT  = 2'd2,
      RX_SHIFT = 2'd3
   } rx_state_e;

   localparam int BYTE_W       = 8;
   localparam int HDR_BITS     = 8;
   localparam int DEF_CRC_W    = 7;
   localparam logic [DEF_CRC_W-1:0] DEF_CRC_POLY = 7'h09;

endpackage

// File: rtl/sdc_crc_serial.sv
module sdc_crc_serial #(
   parameter int              W    = 7,
   parameter logic [W-1:0]    POLY = 7'h09
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic         din,
   output logic [W-1:0] crc
);

   logic [W-1:0] crc_q;
   logic [W-1:0] crc_nx;
   logic         fb;

   assign fb = din ^ crc_q[W-1];

   for (genvar b = 0; b < W; b++) begin : g_tap
      if (b == 0) begin : g_lsb
         assign crc_nx[b] = fb & POLY[b];
      end else begin : g_hi
         assign crc_nx[b] = crc_q[b-1] ^ (fb & POLY[b]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      crc_q <= '0;
      else if (clr)    crc_q <= '0;
      else if (en)     crc_q <= crc_nx;
   end

   assign crc = crc_q;

endmodule

// File: rtl/sdc_rx_fifo.sv
module sdc_rx_fifo #(
   parameter int DEPTH = 17,
   parameter int DW    = 8,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          ptr_rst,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data
);

   logic [DW-1:0] ent_w [DEPTH];
   logic [AW-1:0] rd_ptr_q;

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic [DW-1:0] ent_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              ent_q <= '0;
         else if (wr_en && (wr_addr == AW'(g)))   ent_q <= wr_data;
      end
      assign ent_w[g] = ent_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rd_ptr_q <= '0;
      else if (ptr_rst)  rd_ptr_q <= '0;
      else if (rd_en)    rd_ptr_q <= (rd_ptr_q == AW'(DEPTH-1)) ? '0 : rd_ptr_q + 1'b1;
   end

   assign rd_data = ent_w[rd_ptr_q];

endmodule

// File: rtl/sdc_resp_ctrl.sv
module sdc_resp_ctrl
   import sdc_resp_pkg::*;
#(
   parameter int SHORT_BYTES = 6,
   parameter int LONG_BYTES  = 17,
   parameter int TOUT_TICKS  = 64,
   parameter int CRC_W       = 7,
   parameter int AW          = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_set,
   input  logic             cfg_long,
   input  logic             cfg_crc_off,
   input  logic             cmd_done,
   input  logic             bit_tick,
   input  logic             cmd_in,
   input  logic             eor_ack,
   input  logic [CRC_W-1:0] crc_calc,
   output logic             crc_clr,
   output logic             crc_en,
   output logic             crc_din,
   output logic             wr_en,
   output logic [AW-1:0]    wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic             rx_en,
   output logic             eor_flag,
   output logic             crc_err,
   output logic             fmt_err,
   output logic             tout_err
);

   localparam int SHORT_BITS = SHORT_BYTES * BYTE_W;
   localparam int LONG_BITS  = LONG_BYTES * BYTE_W;
   localparam int IDX_W      = $clog2(LONG_BITS + 1);
   localparam int TC_W       = $clog2(TOUT_TICKS + 1);
   localparam logic [IDX_W-1:0] S_LAST = IDX_W'(SHORT_BITS - 1);
   localparam logic [IDX_W-1:0] L_LAST = IDX_W'(LONG_BITS - 1);
   localparam logic [IDX_W-1:0] S_COVH = IDX_W'(SHORT_BITS - 1 - CRC_W);
   localparam logic [IDX_W-1:0] L_COVH = IDX_W'(LONG_BITS - 1 - CRC_W);
   localparam logic [IDX_W-1:0] L_COVL = IDX_W'(HDR_BITS);
   localparam logic [TC_W-1:0]  T_LAST = TC_W'(TOUT_TICKS - 1);

   rx_state_e            state_q;
   logic                 long_q, crcoff_q, fbad_q;
   logic [IDX_W-1:0]     idx_q;
   logic [TC_W-1:0]      tcnt_q;
   logic [BYTE_W-2:0]    sh_q;
   logic [CRC_W-1:0]     crcrx_q;
   logic                 eor_q, crce_q, fmte_q, toute_q;

   logic                 in_hunt, in_shift, take, arm_go, last;
   logic [IDX_W-1:0]     cur_idx, last_idx, cov_lo, cov_hi;

   assign in_hunt  = (state_q == RX_HUNT);
   assign in_shift = (state_q == RX_SHIFT);
   assign take     = bit_tick && ((in_hunt && !cmd_in) || in_shift);
   assign arm_go   = arm_set && (state_q == RX_IDLE);
   assign cur_idx  = in_shift ? idx_q : '0;
   assign last_idx = long_q ? L_LAST : S_LAST;
   assign cov_lo   = long_q ? L_COVL : '0;
   assign cov_hi   = long_q ? L_COVH : S_COVH;
   assign last     = in_shift && (cur_idx == last_idx);

   assign crc_clr  = arm_go;
   assign crc_en   = take && (cur_idx >= cov_lo) && (cur_idx < cov_hi);
   assign crc_din  = cmd_in;
   assign wr_en    = take && (cur_idx[2:0] == 3'b111);
   assign wr_addr  = AW'(cur_idx >> 3);
   assign wr_data  = {sh_q, cmd_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= RX_IDLE;
         long_q   <= 1'b0;
         crcoff_q <= 1'b0;
         fbad_q   <= 1'b0;
         idx_q    <= '0;
         tcnt_q   <= '0;
         sh_q     <= '0;
         crcrx_q  <= '0;
         eor_q    <= 1'b0;
         crce_q   <= 1'b0;
         fmte_q   <= 1'b0;
         toute_q  <= 1'b0;
      end else begin
         if (eor_ack) eor_q <= 1'b0;
         if (take) sh_q <= {sh_q[BYTE_W-3:0], cmd_in};
         unique case (state_q)
            RX_IDLE: begin
               if (arm_set) begin
                  state_q  <= RX_ARMED;
                  long_q   <= cfg_long;
                  crcoff_q <= cfg_crc_off;
                  fbad_q   <= 1'b0;
                  eor_q    <= 1'b0;
                  crce_q   <= 1'b0;
                  fmte_q   <= 1'b0;
                  toute_q  <= 1'b0;
               end
            end
            RX_ARMED: begin
               if (cmd_done) begin
                  state_q <= RX_HUNT;
                  tcnt_q  <= '0;
               end
            end
            RX_HUNT: begin
               if (bit_tick) begin
                  if (!cmd_in) begin
                     state_q <= RX_SHIFT;
                     idx_q   <= IDX_W'(1);
                  end else if (tcnt_q == T_LAST) begin
                     state_q <= RX_IDLE;
                     eor_q   <= 1'b1;
                     toute_q <= 1'b1;
                  end else begin
                     tcnt_q <= tcnt_q + 1'b1;
                  end
               end
            end
            RX_SHIFT: begin
               if (bit_tick) begin
                  idx_q <= idx_q + 1'b1;
                  if ((idx_q == IDX_W'(1)) && cmd_in) fbad_q <= 1'b1;
                  if ((idx_q >= cov_hi) && (idx_q < last_idx))
                     crcrx_q <= {crcrx_q[CRC_W-2:0], cmd_in};
                  if (last) begin
                     state_q <= RX_IDLE;
                     eor_q   <= 1'b1;
                     fmte_q  <= fbad_q | ~cmd_in;
                     crce_q  <= ~crcoff_q && (crc_calc != crcrx_q);
                  end
               end
            end
            default: state_q <= RX_IDLE;
         endcase
      end
   end

   assign rx_en    = (state_q != RX_IDLE);
   assign eor_flag = eor_q;
   assign crc_err  = crce_q;
   assign fmt_err  = fmte_q;
   assign tout_err = toute_q;

endmodule

// File: rtl/sdc_resp_rx.sv
module sdc_resp_rx
   import sdc_resp_pkg::*;
#(
   parameter int                   SHORT_BYTES = 6,
   parameter int                   LONG_BYTES  = 17,
   parameter int                   TOUT_TICKS  = 64,
   parameter int                   CRC_W       = DEF_CRC_W,
   parameter logic [CRC_W-1:0]     CRC_POLY    = DEF_CRC_POLY
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               arm_set,
   input  logic               cfg_long,
   input  logic               cfg_crc_off,
   input  logic               cmd_done,
   input  logic               bit_tick,
   input  logic               cmd_in,
   input  logic               eor_ack,
   input  logic               ptr_rst,
   input  logic               rd_en,
   output logic [BYTE_W-1:0]  rd_data,
   output logic               rx_en,
   output logic               eor_flag,
   output logic               crc_err,
   output logic               fmt_err,
   output logic               tout_err
);

   localparam int FIFO_DEPTH = LONG_BYTES;
   localparam int AW         = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;

   if (SHORT_BYTES < 2 || LONG_BYTES <= SHORT_BYTES) begin : g_bad_len
      $error("sdc_resp_rx: reply lengths out of range");
   end
   if (CRC_W < 2 || CRC_W > BYTE_W - 1) begin : g_bad_crc
      $error("sdc_resp_rx: CRC width must fit in the last byte");
   end
   if (TOUT_TICKS < 1) begin : g_bad_tout
      $error("sdc_resp_rx: timeout must be at least one strobe");
   end

   logic               crc_clr, crc_en, crc_din;
   logic [CRC_W-1:0]   crc_calc;
   logic               wr_en;
   logic [AW-1:0]      wr_addr;
   logic [BYTE_W-1:0]  wr_data;

   sdc_resp_ctrl #(
      .SHORT_BYTES (SHORT_BYTES),
      .LONG_BYTES  (LONG_BYTES),
      .TOUT_TICKS  (TOUT_TICKS),
      .CRC_W       (CRC_W),
      .AW          (AW)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .arm_set     (arm_set),
      .cfg_long    (cfg_long),
      .cfg_crc_off (cfg_crc_off),
      .cmd_done    (cmd_done),
      .bit_tick    (bit_tick),
      .cmd_in      (cmd_in),
      .eor_ack     (eor_ack),
      .crc_calc    (crc_calc),
      .crc_clr     (crc_clr),
      .crc_en      (crc_en),
      .crc_din     (crc_din),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .rx_en       (rx_en),
      .eor_flag    (eor_flag),
      .crc_err     (crc_err),
      .fmt_err     (fmt_err),
      .tout_err    (tout_err)
   );

   sdc_crc_serial #(
      .W    (CRC_W),
      .POLY (CRC_POLY)
   ) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (crc_clr),
      .en    (crc_en),
      .din   (crc_din),
      .crc   (crc_calc)
   );

   sdc_rx_fifo #(
      .DEPTH (FIFO_DEPTH),
      .DW    (BYTE_W)
   ) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .ptr_rst (ptr_rst),
      .rd_en   (rd_en),
      .rd_data (rd_data)
   );

endmodule

// File: rtl/sdc_resp_rx_chk.sv
module sdc_resp_rx_chk (
   input logic clk,
   input logic rst_n,
   input logic arm_set,
   input logic cmd_done,
   input logic bit_tick,
   input logic eor_ack,
   input logic rx_en,
   input logic eor_flag,
   input logic crc_err,
   input logic fmt_err,
   input logic tout_err
);

   AST_BUSY_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      rx_en |-> !eor_flag && !crc_err && !fmt_err && !tout_err);             // R1

   AST_EOR_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eor_flag) |-> $fell(rx_en));                                      // R9

   AST_EOR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      eor_flag && !eor_ack && !arm_set |=> eor_flag);                         // R9

   AST_CRC_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(crc_err) |-> $rose(eor_flag));                                    // R5

   AST_TOUT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      tout_err |-> !crc_err && !fmt_err);                                     // R8

   AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_tick && !arm_set && !cmd_done && !eor_ack |=> $stable(rx_en) && $stable(eor_flag)); // R12

endmodule

bind sdc_resp_rx sdc_resp_rx_chk chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .arm_set  (arm_set),
   .cmd_done (cmd_done),
   .bit_tick (bit_tick),
   .eor_ack  (eor_ack),
   .rx_en    (rx_en),
   .eor_flag (eor_flag),
   .crc_err  (crc_err),
   .fmt_err  (fmt_err),
   .tout_err (tout_err)
);

// File: tb/sdc_resp_rx_tb_top.sv
module sdc_resp_rx_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       arm_set = 1'b0, cfg_long = 1'b0, cfg_crc_off = 1'b0;
   logic       cmd_done = 1'b0, bit_tick = 1'b0, cmd_in = 1'b1;
   logic       eor_ack = 1'b0, ptr_rst = 1'b0, rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       rx_en, eor_flag, crc_err, fmt_err, tout_err;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   sdc_resp_rx dut_i (
      .clk(clk), .rst_n(rst_n), .arm_set(arm_set), .cfg_long(cfg_long),
      .cfg_crc_off(cfg_crc_off), .cmd_done(cmd_done), .bit_tick(bit_tick),
      .cmd_in(cmd_in), .eor_ack(eor_ack), .ptr_rst(ptr_rst), .rd_en(rd_en),
      .rd_data(rd_data), .rx_en(rx_en), .eor_flag(eor_flag), .crc_err(crc_err),
      .fmt_err(fmt_err), .tout_err(tout_err)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [6:0] crc7(input logic [135:0] fr, input int hi, input int lo);
      logic [6:0] c = '0;
      for (int i = hi; i >= lo; i--) begin
         logic fb = fr[i] ^ c[6];
         c = {c[5:0], 1'b0};
         if (fb) c = c ^ 7'h09;
      end
      return c;
   endfunction

   function automatic logic [135:0] mk_short(input logic [5:0] ix, input logic [31:0] arg);
      logic [135:0] fr = '0;
      fr[47:8] = {2'b00, ix, arg};
      fr[7:1]  = crc7(fr, 47, 8);
      fr[0]    = 1'b1;
      return fr;
   endfunction

   function automatic logic [135:0] mk_long(input logic [119:0] pl);
      logic [135:0] fr = '0;
      fr[135:128] = 8'h3F;
      fr[127:8]   = pl;
      fr[7:1]     = crc7(fr, 127, 8);
      fr[0]       = 1'b1;
      return fr;
   endfunction

   // all tasks start and end just after a falling edge
   task automatic send_bit(input logic b, input int gap);
      cmd_in = b; bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0; cmd_in = 1'b1;
      for (int g = 0; g < gap; g++) begin
         cmd_in = ~b;
         @(negedge clk);
      end
      cmd_in = 1'b1;
   endtask

   task automatic send_frame(input logic [135:0] fr, input int n, input int gap);
      for (int i = n - 1; i >= 0; i--) send_bit(fr[i], gap);
   endtask

   task automatic arm(input logic lng, input logic off);
      arm_set = 1'b1; cfg_long = lng; cfg_crc_off = off;
      @(negedge clk);
      arm_set = 1'b0;
   endtask

   task automatic cmd_end();
      cmd_done = 1'b1;
      @(negedge clk);
      cmd_done = 1'b0;
   endtask

   task automatic pulse_ptr_rst();
      ptr_rst = 1'b1;
      @(negedge clk);
      ptr_rst = 1'b0;
   endtask

   task automatic read_bytes(input string req, input logic [135:0] fr, input int n);
      pulse_ptr_rst();
      for (int k = 0; k < n / 8; k++) begin
         check(req, rd_data, fr[n - 1 - 8*k -: 8]);
         rd_en = 1'b1;
         @(negedge clk);
         rd_en = 1'b0;
      end
   endtask

   task automatic ack();
      eor_ack = 1'b1;
      @(negedge clk);
      eor_ack = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 rst rx_en", rx_en, 0);
      check("R1 rst eor", eor_flag, 0);
      check("R1 rst status", {crc_err, fmt_err, tout_err}, 0);
   endtask

   task automatic t_short_ok();
      logic [135:0] fr = mk_short(6'h11, 32'hA5C3_0F96);
      arm(1'b0, 1'b0);
      check("R1 armed", rx_en, 1);
      for (int i = 0; i < 3; i++) send_bit(1'b0, 0);
      check("R2 no start before cmd_done", {rx_en, eor_flag}, 2'b10);
      cmd_end();
      for (int i = 0; i < 5; i++) send_bit(1'b1, 0);
      send_frame(fr, 48, 0);
      check("R9 eor set", eor_flag, 1);
      check("R9 busy cleared", rx_en, 0);
      check("R3 short clean status", {crc_err, fmt_err, tout_err}, 0);
      read_bytes("R3 short byte", fr, 48);
      check("R9 eor sticky", eor_flag, 1);
      ack();
      check("R9 eor acked", eor_flag, 0);
   endtask

   task automatic t_long_ok();
      logic [135:0] fr = mk_long(120'h0123_4567_89AB_CDEF_FEDC_BA98_7654_32);
      arm(1'b1, 1'b0);
      cmd_end();
      send_bit(1'b1, 2);
      send_frame(fr, 136, 1);
      check("R4 long eor", {eor_flag, rx_en}, 2'b10);
      check("R12 long gapped status", {crc_err, fmt_err, tout_err}, 0);
      read_bytes("R4 long byte", fr, 136);
      check("R10 pointer wraps to 0", rd_data, fr[135 -: 8]);
      ptr_rst = 1'b1;
      rd_en = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rd_en = 1'b0;
      ptr_rst = 1'b0;
      check("R10 ptr_rst holds pointer", rd_data, fr[135 -: 8]);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      check("R10 advance", rd_data, fr[127 -: 8]);
      ack();
   endtask

   task automatic t_crc_bad();
      logic [135:0] fr = mk_short(6'h02, 32'h0000_1234);
      fr[3] = ~fr[3];
      arm(1'b0, 1'b0);
      cmd_end();
      send_frame(fr, 48, 0);
      check("R5 crc mismatch", crc_err, 1);
      check("R5 fmt clean", fmt_err, 0);
      ack();
      arm(1'b0, 1'b0);
      check("R1 arm clears crc_err", crc_err, 0);
      cmd_end();
      fr = mk_long(120'hDEAD_BEEF_0000_1111_2222_3333_4444_55);
      fr[60] = ~fr[60];
      send_frame(fr, 48, 0);
      check("R11 short frame mode kept", {eor_flag, crc_err}, 2'b11);
      ack();
   endtask

   task automatic t_crc_off();
      logic [135:0] fr = mk_short(6'h29, 32'hFFFF_0000);
      fr[5] = ~fr[5];
      arm(1'b0, 1'b1);
      cmd_end();
      send_frame(fr, 48, 0);
      check("R6 crc ignored", {eor_flag, crc_err, fmt_err}, 3'b100);
      ack();
   endtask

   task automatic t_fmt();
      logic [135:0] fr = '0;
      fr[47:8] = {2'b01, 6'h05, 32'h8000_0001};
      fr[7:1] = crc7(fr, 47, 8);
      fr[0] = 1'b1;
      arm(1'b0, 1'b0);
      cmd_end();
      send_frame(fr, 48, 0);
      check("R7 tx bit error", {fmt_err, crc_err}, 2'b10);
      ack();
      fr = mk_short(6'h05, 32'h8000_0001);
      fr[0] = 1'b0;
      arm(1'b0, 1'b0);
      cmd_end();
      send_frame(fr, 48, 0);
      check("R7 end bit error", {eor_flag, fmt_err, crc_err}, 3'b110);
      ack();
   endtask

   task automatic t_timeout();
      arm(1'b0, 1'b0);
      cmd_end();
      for (int i = 0; i < 63; i++) send_bit(1'b1, 0);
      check("R8 before limit", {rx_en, eor_flag, tout_err}, 3'b100);
      send_bit(1'b1, 0);
      check("R8 timeout", {rx_en, eor_flag, tout_err}, 3'b011);
      check("R8 no other status", {crc_err, fmt_err}, 0);
      ack();
   endtask

   task automatic t_cfg_latch();
      logic [135:0] fr = mk_long(120'h5555_AAAA_0F0F_F0F0_1234_5678_9ABC_DE);
      arm(1'b1, 1'b0);
      cfg_long = 1'b0;
      cfg_crc_off = 1'b1;
      cmd_end();
      send_frame(fr >> 88, 48, 0);
      check("R11 long kept after cfg change", {rx_en, eor_flag}, 2'b10);
      send_frame(fr, 88, 0);
      check("R11 long completes", {eor_flag, crc_err, fmt_err}, 3'b100);
      ack();
      fr[70] = ~fr[70];
      arm(1'b1, 1'b0);
      cfg_crc_off = 1'b1;
      cmd_end();
      send_frame(fr, 136, 0);
      check("R11 crc check kept on", crc_err, 1);
      ack();
   endtask

   initial begin : wdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_short_ok();
      t_long_ok();
      t_crc_bad();
      t_crc_off();
      t_fmt();
      t_timeout();
      t_cfg_latch();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule